// File: doc/BRIEF.md
# Row Command Packet Framer and Device Selector

This block sits at the receive side of a narrow row command bus that moves each command as a burst of eight beats over three lanes. It gathers the beats into one 24-bit word. It finds the start of each burst from a pair of code bits that also carry the top bit of the target device address. It compares the full six-bit device address with a locally held identity, and it splits the word into a bank number and either a row address or an operation code.

Each burst produces a single-cycle strobe with a type flag, the bank and payload fields, a select flag and a broadcast flag. The local identity is a small register. It clears to zero on reset and is loaded through a one-cycle write port. Bank timing, the storage core and the column command path belong to other blocks.

The first beat of a burst must show at least one of its two code bits high. Once a burst has started, the next seven beats are taken as data without any look for a new start. This keeps payload bits that happen to look like code bits from breaking the stream.

Top module: `rpd_row_decoder`

## Requirements
- R1: After reset `cmd_vld_o`, `sel_o` and `bcast_o` are low and the held identity is 000000, so a targeted burst addressed to device 0 is selected without any write.
- R2: A burst is 8 beats of `row_i`. Beat k carries word bits [23-3k : 21-3k] (lane 2 = highest bit). The word is {tt, tf, av, dev[4:0], bank[4:0], payload[10:0]}, MSB first. `cmd_vld_o` pulses high for exactly one cycle, in the cycle after the clock edge that samples the eighth beat.
- R3: While no burst is in progress, a beat with tt = tf = 0 starts nothing, whatever lane 0 carries, and produces no strobe.
- R4: With {tt,tf} = 10 the sixth device bit is 1, and with 01 it is 0. `sel_o` is high with the strobe only when all six device bits equal the held identity. Otherwise the strobe still appears with `sel_o` low.
- R5: With {tt,tf} = 11 the burst is a broadcast: `sel_o` and `bcast_o` are both high with the strobe, whatever the identity.
- R6: av = 1 marks an activate. `is_act_o` goes high, and `bank_o` and `row_o` take the bank and payload fields. av = 0 marks a row operation. `is_act_o` goes low, `op_o` takes the payload and `row_o` keeps its previous value. `row_o` and `op_o` change only at a strobe of their own type.
- R7: Beats 2 to 8 of a burst are never taken as a new start, even when their upper lanes are high. A new burst may begin on the beat right after the eighth beat, so strobes are never closer than 8 cycles apart.
- R8: `id_we_i` loads `id_wdata_i` into the identity at the clock edge. A burst whose eighth beat is sampled at that same edge is compared against the previous identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one beat sampled per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_i | input | 3 | Row bus lanes, lane 2 highest |
| id_we_i | input | 1 | Identity write enable |
| id_wdata_i | input | 6 | Identity write value |
| cmd_vld_o | output | 1 | One-cycle strobe per received burst |
| sel_o | output | 1 | Burst accepted by this device (valid with strobe) |
| bcast_o | output | 1 | Burst was a broadcast (valid with strobe) |
| is_act_o | output | 1 | Burst type: 1 activate, 0 row operation |
| bank_o | output | 5 | Bank field of the last burst |
| row_o | output | 11 | Row address of the last activate |
| op_o | output | 11 | Operation code of the last row operation |

## Verification
Two pairs of events can land on the same clock edge. An identity write can coincide with the sampling of a burst's final beat. The bench places the write on exactly that beat and expects the selection result from the identity held before the write. It then sends bursts that match only the new identity or only the old one, and expects selection to follow the new value. The end of one burst can also meet the start of the next. The bench sends two bursts with no gap between them, filled with ones so that their inner beats look like start codes, and requires exactly two strobes with the right fields, eight cycles apart.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

   // Code carried by the two framing lanes of the first beat: {tt, tf}
   typedef enum logic [1:0] {
      FRM_NONE = 2'b00,
      FRM_DEV0 = 2'b01,
      FRM_DEV1 = 2'b10,
      FRM_ALL  = 2'b11
   } frm_code_e;

   // Number of header bits ahead of the device field: tt, tf, av
   localparam int HDR_BITS = 3;

endpackage

// File: rtl/rpd_id_reg.sv
module rpd_id_reg #(
   parameter int DEV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [DEV_W-1:0] wdata_i,
   output logic [DEV_W-1:0] id_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_o <= '0;
      end else if (we_i) begin
         id_o <= wdata_i;
      end
   end

endmodule

// File: rtl/rpd_deser.sv
module rpd_deser #(
   parameter int LANES = 3,
   parameter int BEATS = 8,
   parameter int PKT_W = LANES * BEATS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_i,
   input  logic             frame_i,
   output logic             last_o,
   output logic [PKT_W-1:0] word_o
);

   localparam int HOLD_W = PKT_W - LANES;
   localparam int CW     = (BEATS > 2) ? $clog2(BEATS) : 1;
   localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [HOLD_W-1:0] hold_q;
   logic              shift_en;

   assign shift_en = busy_q | frame_i;
   assign last_o   = busy_q && (cnt_q == LAST_BEAT);
   assign word_o   = {hold_q, lane_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (frame_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
         end
      end else if (cnt_q == LAST_BEAT) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end

   generate
      if (HOLD_W == LANES) begin : g_one_beat
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (shift_en) begin
               hold_q <= lane_i;
            end
         end
      end else begin : g_multi_beat
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (shift_en) begin
               hold_q <= {hold_q[HOLD_W-LANES-1:0], lane_i};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rpd_frame_match.sv
module rpd_frame_match
   import rpd_pkg::*;
#(
   parameter int PKT_W    = 24,
   parameter int DEV_W    = 6,
   parameter int BANK_W   = 5,
   parameter int PAY_W    = 11,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [PKT_W-1:0]  word_i,
   input  logic [DEV_W-1:0]  id_i,
   output logic              framed_o,
   output logic              sel_o,
   output logic              bcast_o,
   output logic              act_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [PAY_W-1:0]  pay_o
);

   localparam int AV_POS = PKT_W - HDR_BITS;
   localparam int DEV_HI = AV_POS - 1;
   localparam int DEV_LO = AV_POS - (DEV_W - 1);
   localparam int BNK_HI = DEV_LO - 1;
   localparam int BNK_LO = DEV_LO - BANK_W;

   frm_code_e code;
   logic      low_match;
   logic      all_acc;

   assign code      = frm_code_e'(word_i[PKT_W-1 -: 2]);
   assign low_match = (word_i[DEV_HI:DEV_LO] == id_i[DEV_W-2:0]);
   assign act_o     = word_i[AV_POS];
   assign bank_o    = word_i[BNK_HI:BNK_LO];
   assign pay_o     = word_i[PAY_W-1:0];

   generate
      if (BCAST_EN) begin : g_bcast_on
         assign all_acc = 1'b1;
      end else begin : g_bcast_off
         assign all_acc = 1'b0;
      end
   endgenerate

   always_comb begin
      framed_o = 1'b1;
      sel_o    = 1'b0;
      bcast_o  = 1'b0;
      unique case (code)
         FRM_NONE: framed_o = 1'b0;
         FRM_DEV0: sel_o    = low_match && !id_i[DEV_W-1];
         FRM_DEV1: sel_o    = low_match &&  id_i[DEV_W-1];
         FRM_ALL: begin
            sel_o   = all_acc;
            bcast_o = all_acc;
         end
         default: framed_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rpd_row_decoder.sv
module rpd_row_decoder #(
   parameter int LANES    = 3,
   parameter int BEATS    = 8,
   parameter int DEV_W    = 6,
   parameter int BANK_W   = 5,
   parameter bit BCAST_EN = 1'b1,
   localparam int PKT_W   = LANES * BEATS,
   localparam int PAY_W   = PKT_W - rpd_pkg::HDR_BITS - (DEV_W - 1) - BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  row_i,
   input  logic              id_we_i,
   input  logic [DEV_W-1:0]  id_wdata_i,
   output logic              cmd_vld_o,
   output logic              sel_o,
   output logic              bcast_o,
   output logic              is_act_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [PAY_W-1:0]  row_o,
   output logic [PAY_W-1:0]  op_o
);

   generate
      if (LANES < 3) begin : g_bad_lanes
         $error("rpd_row_decoder: LANES must be at least 3");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("rpd_row_decoder: BEATS must be at least 2");
      end
      if (DEV_W < 2) begin : g_bad_dev
         $error("rpd_row_decoder: DEV_W must be at least 2");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("rpd_row_decoder: no room left for the payload field");
      end
   endgenerate

   logic [DEV_W-1:0]  id_q;
   logic              frame_hit;
   logic              last_beat;
   logic [PKT_W-1:0]  word;
   logic              framed_c;
   logic              sel_c;
   logic              bcast_c;
   logic              act_c;
   logic [BANK_W-1:0] bank_c;
   logic [PAY_W-1:0]  pay_c;
   logic              take;

   assign frame_hit = row_i[LANES-1] | row_i[LANES-2];

   rpd_id_reg #(
      .DEV_W (DEV_W)
   ) id_reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (id_we_i),
      .wdata_i (id_wdata_i),
      .id_o    (id_q)
   );

   rpd_deser #(
      .LANES (LANES),
      .BEATS (BEATS),
      .PKT_W (PKT_W)
   ) deser_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_i  (row_i),
      .frame_i (frame_hit),
      .last_o  (last_beat),
      .word_o  (word)
   );

   rpd_frame_match #(
      .PKT_W    (PKT_W),
      .DEV_W    (DEV_W),
      .BANK_W   (BANK_W),
      .PAY_W    (PAY_W),
      .BCAST_EN (BCAST_EN)
   ) match_i (
      .word_i   (word),
      .id_i     (id_q),
      .framed_o (framed_c),
      .sel_o    (sel_c),
      .bcast_o  (bcast_c),
      .act_o    (act_c),
      .bank_o   (bank_c),
      .pay_o    (pay_c)
   );

   assign take = last_beat & framed_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_vld_o <= 1'b0;
         sel_o     <= 1'b0;
         bcast_o   <= 1'b0;
         is_act_o  <= 1'b0;
         bank_o    <= '0;
         row_o     <= '0;
         op_o      <= '0;
      end else begin
         cmd_vld_o <= take;
         sel_o     <= take & sel_c;
         bcast_o   <= take & bcast_c;
         if (take) begin
            is_act_o <= act_c;
            bank_o   <= bank_c;
            if (act_c) begin
               row_o <= pay_c;
            end else begin
               op_o  <= pay_c;
            end
         end
      end
   end

endmodule

// File: rtl/rpd_row_decoder_chk.sv
module rpd_row_decoder_chk #(
   parameter int LANES  = 3,
   parameter int BEATS  = 8,
   parameter int PAY_W  = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] row_i,
   input logic             cmd_vld_o,
   input logic             sel_o,
   input logic             bcast_o,
   input logic             is_act_o,
   input logic [PAY_W-1:0] row_o,
   input logic [PAY_W-1:0] op_o
);

   localparam int GW = $clog2(BEATS + 1);
   localparam logic [GW-1:0] SAT  = GW'(BEATS);
   localparam logic [GW-1:0] MING = GW'(BEATS - 1);

   logic [GW-1:0] gap_q;
   logic [GW-1:0] quiet_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q   <= SAT;
         quiet_q <= SAT;
      end else begin
         if (cmd_vld_o)
            gap_q <= '0;
         else if (gap_q < SAT)
            gap_q <= gap_q + GW'(1);
         if (row_i[LANES-1] | row_i[LANES-2])
            quiet_q <= '0;
         else if (quiet_q < SAT)
            quiet_q <= quiet_q + GW'(1);
      end
   end

   // R4
   sel_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o |-> cmd_vld_o);

   // R5
   bcast_implies_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_o |-> (sel_o && cmd_vld_o));

   // R6
   row_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_o) |-> (cmd_vld_o && is_act_o));

   // R6
   op_field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(op_o) |-> (cmd_vld_o && !is_act_o));

   // R3
   no_strobe_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> (quiet_q < SAT));

   // R7
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |-> (gap_q >= MING));

endmodule

bind rpd_row_decoder rpd_row_decoder_chk #(
   .LANES (LANES),
   .BEATS (BEATS),
   .PAY_W (PAY_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_i     (row_i),
   .cmd_vld_o (cmd_vld_o),
   .sel_o     (sel_o),
   .bcast_o   (bcast_o),
   .is_act_o  (is_act_o),
   .row_o     (row_o),
   .op_o      (op_o)
);

// File: tb/rpd_row_decoder_tb_top.sv
module rpd_row_decoder_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      string      tag;
      logic       sel;
      logic       bcast;
      logic       act;
      logic [4:0] bank;
      logic [10:0] row;
      logic [10:0] op;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  row_i = '0;
   logic        id_we_i = 1'b0;
   logic [5:0]  id_wdata_i = '0;
   logic        cmd_vld_o, sel_o, bcast_o, is_act_o;
   logic [4:0]  bank_o;
   logic [10:0] row_o, op_o;

   exp_t        exp_q[$];
   int          checks = 0;
   int          bad = 0;
   int          strobes = 0;
   logic [5:0]  id_model = '0;
   logic [10:0] row_model = '0;
   logic [10:0] op_model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rpd_row_decoder dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_i      (row_i),
      .id_we_i    (id_we_i),
      .id_wdata_i (id_wdata_i),
      .cmd_vld_o  (cmd_vld_o),
      .sel_o      (sel_o),
      .bcast_o    (bcast_o),
      .is_act_o   (is_act_o),
      .bank_o     (bank_o),
      .row_o      (row_o),
      .op_o       (op_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   task automatic idle(input int n, input logic [2:0] pattern = 3'b000);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         row_i   = pattern;
         id_we_i = 1'b0;
      end
   endtask

   task automatic wr_id(input logic [5:0] v);
      @(negedge clk);
      row_i      = 3'b000;
      id_we_i    = 1'b1;
      id_wdata_i = v;
      @(negedge clk);
      id_we_i    = 1'b0;
      id_model   = v;
   endtask

   // Drives one burst; expectation pushed from the requirements, with the
   // identity known before any write placed on the final beat (R8).
   task automatic send(input string tag, input logic tt, input logic tf,
                       input logic av, input logic [4:0] dlo,
                       input logic [4:0] bk, input logic [10:0] pl,
                       input bit wr = 1'b0, input logic [5:0] wv = '0);
      logic [23:0] word;
      exp_t        e;
      word = {tt, tf, av, dlo, bk, pl};
      if (tt | tf) begin
         e.tag   = tag;
         e.bcast = tt & tf;
         e.sel   = (tt & tf) ? 1'b1 : (id_model == {tt, dlo});
         e.act   = av;
         e.bank  = bk;
         if (av) row_model = pl;
         else    op_model  = pl;
         e.row   = row_model;
         e.op    = op_model;
         exp_q.push_back(e);
      end
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         row_i   = word[23-3*k -: 3];
         id_we_i = (k == 7) && wr;
         if ((k == 7) && wr) id_wdata_i = wv;
      end
      if (wr) id_model = wv;
   endtask

   // Monitor: compare each strobe against the oldest expectation
   always @(negedge clk) begin
      if (rst_n && cmd_vld_o) begin
         strobes++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "strobe with no burst sent", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(sel_o == e.sel, e.tag, "R4 sel_o", 32'(sel_o), 32'(e.sel));
            check(bcast_o == e.bcast, e.tag, "R5 bcast_o", 32'(bcast_o), 32'(e.bcast));
            check(is_act_o == e.act, e.tag, "R6 is_act_o", 32'(is_act_o), 32'(e.act));
            check(bank_o == e.bank, e.tag, "R2 bank_o", 32'(bank_o), 32'(e.bank));
            check(row_o == e.row, e.tag, "R6 row_o", 32'(row_o), 32'(e.row));
            check(op_o == e.op, e.tag, "R6 op_o", 32'(op_o), 32'(e.op));
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin : main
      int base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cmd_vld_o == 1'b0, "R1", "cmd_vld_o after reset", 32'(cmd_vld_o), 0);
      check(sel_o == 1'b0, "R1", "sel_o after reset", 32'(sel_o), 0);
      check(bcast_o == 1'b0, "R1", "bcast_o after reset", 32'(bcast_o), 0);

      // R1 identity starts at zero; R2 format; R6 activate
      send("R1", 1'b0, 1'b1, 1'b1, 5'h00, 5'h03, 11'h2A5);
      idle(3);

      wr_id(6'b101101);
      // R4 match on high device bit set
      send("R4", 1'b1, 1'b0, 1'b1, 5'b01101, 5'h1F, 11'h7FF);
      idle(2);
      // R4 high device bit differs
      send("R4", 1'b0, 1'b1, 1'b0, 5'b01101, 5'h04, 11'h155);
      idle(2);
      // R4 low bits differ; R6 row loads even when not selected
      send("R4", 1'b1, 1'b0, 1'b1, 5'b01100, 5'h02, 11'h123);
      idle(2);
      // R5 broadcast row operation
      send("R5", 1'b1, 1'b1, 1'b0, 5'h00, 5'h09, 11'h0F0);
      idle(10);

      // R3 idle beats with only lane 0 toggled start nothing
      base = strobes;
      idle(20, 3'b001);
      idle(10);
      check(strobes == base, "R3", "strobes during idle", 32'(strobes), 32'(base));

      // R7 back-to-back bursts with start-like inner beats
      base = strobes;
      send("R7", 1'b1, 1'b0, 1'b1, 5'b01101, 5'h1F, 11'h7FF);
      send("R7", 1'b1, 1'b1, 1'b0, 5'h1F, 5'h1E, 11'h7FE);
      idle(10);
      check(strobes == base + 2, "R7", "strobe count for adjacent bursts",
            32'(strobes), 32'(base + 2));

      // R8 write on the final beat: old identity decides this burst
      send("R8", 1'b1, 1'b0, 1'b1, 5'b01101, 5'h05, 11'h321, 1'b1, 6'b010011);
      idle(2);
      send("R8", 1'b0, 1'b1, 1'b0, 5'b10011, 5'h06, 11'h0AA);
      idle(2);
      send("R8", 1'b1, 1'b0, 1'b1, 5'b01101, 5'h07, 11'h456);
      idle(12);

      check(exp_q.size() == 0, "R2", "bursts left without strobe",
            32'(exp_q.size()), 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule